// File: doc/BRIEF.md
# Privileged-Mode Trap Dispatch Unit

This block steers control flow into and out of privileged handler code. When a trap request arrives it picks the handler address from a handler base register and a fixed offset chosen by the fault code. It records where execution should resume and, if the trapping instruction ran outside privileged mode, it switches in a shadow bank of integer registers. When a return-from-handler request arrives it jumps back to the saved resume address. It leaves the shadow bank only when bit 0 of that address is clear. A return attempted outside privileged mode is refused and flagged as an unimplemented-opcode fault.

Privileged mode means that bit 0 of the current program counter is 1. The block also contains a small register file model. Eight of its entries (8 through 14, and 25) have shadow copies. Which copy is visible for reads and writes depends on the shadow flag.

Top module: `trap_dispatch`

## Requirements
- R1: During synchronous reset (rst_n low) the PC output becomes base_i + 0x0001, the next-PC output becomes that value + 4, the shadow flag is 1, the saved resume address is 0, both error pulses are 0 and every register file entry (main and shadow) is 0.
- R2: On a trap the PC output becomes base_i plus the offset for fault_i, one cycle after the request. The fault_i codes and their offsets are: 0 reset 0x0001, 1 machine check 0x0401, 2 arithmetic 0x0501, 3 interrupt 0x0101, 4 data-TLB miss in native mode 0x0201, 5 data-TLB miss in privileged mode 0x0281, 6 alignment 0x0301, 7 data fault or access violation 0x0381, 8 instruction-TLB miss or fault 0x0181, 9 instruction access violation 0x0081, 10 unimplemented opcode 0x0481, 11 FP disabled 0x0581, 12 privileged call 0x2001, 13 integer overflow 0x0501.
- R3: The next-PC output is always the PC output plus 4.
- R4: A trap saves pc_i as the resume address. The one exception is an interrupt (code 3) taken while pc_i[0] is 1; in that case the previous resume address is kept.
- R5: A privileged-call trap (code 12) saves pc_i + 4 as the resume address.
- R6: A trap with pc_i[0] = 0 sets the shadow flag. A trap with pc_i[0] = 1 leaves the shadow flag unchanged.
- R7: A return request with pc_i[0] = 0 pulses rei_fault_o for one cycle and leaves the PC, the resume address and the shadow flag unchanged.
- R8: A return request with pc_i[0] = 1 loads the resume address into the PC. The shadow flag is cleared if bit 0 of the resume address is 0 and kept otherwise.
- R9: Register addresses 8 to 14 and 25 read and write the shadow copy while the shadow flag is 1 and the main copy while it is 0. All other addresses always use the main copy. Reads are combinational and writes take effect at the clock edge.
- R10: swap_err_o pulses for one cycle when a trap from non-privileged mode arrives while the shadow flag is already 1. It also pulses when a return that would clear the flag arrives while the flag is already 0.
- R11: If a trap and a return are requested in the same cycle, the trap is performed and the return is ignored. In that case rei_fault_o stays 0.
- R12: The unused fault codes 14 and 15 dispatch to the unimplemented-opcode offset 0x0481.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_i | input | AW | PC of the instruction requesting the trap or return |
| fault_i | input | 4 | Fault code for a trap |
| trap_i | input | 1 | Trap request strobe |
| rei_i | input | 1 | Return-from-handler request strobe |
| base_i | input | AW | Handler base address |
| rf_we | input | 1 | Register file write enable |
| rf_waddr | input | RA | Register file write address |
| rf_wdata | input | DW | Register file write data |
| rf_raddr | input | RA | Register file read address |
| rf_rdata | output | DW | Register file read data (visible copy) |
| pc_o | output | AW | New program counter |
| npc_o | output | AW | Next program counter |
| exc_o | output | AW | Saved resume address |
| shadow_o | output | 1 | Shadow bank active |
| rei_fault_o | output | 1 | Return outside privileged mode (one-cycle pulse) |
| swap_err_o | output | 1 | Redundant swap request (one-cycle pulse) |

## Verification
Every registered result of a request appears one clock edge after the request is sampled: the PC, the next PC, the resume address, the shadow flag and both error pulses. Register file reads are combinational on the read address, and a write is visible after the edge that stores it. The bench drives each request on a falling edge and lets one rising edge pass. It then compares all registered outputs at the following falling edge, while both error pulses are still high, and removes the request before the next rising edge. Register reads are checked a short delay after the read address changes, with no clock edge in between.

// File: rtl/trap_dispatch.sv
module trap_dispatch #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int NREG = 32,
  localparam int RA  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] pc_i,
  input  logic [3:0]    fault_i,
  input  logic          trap_i,
  input  logic          rei_i,
  input  logic [AW-1:0] base_i,
  input  logic          rf_we,
  input  logic [RA-1:0] rf_waddr,
  input  logic [DW-1:0] rf_wdata,
  input  logic [RA-1:0] rf_raddr,
  output logic [DW-1:0] rf_rdata,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] npc_o,
  output logic [AW-1:0] exc_o,
  output logic          shadow_o,
  output logic          rei_fault_o,
  output logic          swap_err_o
);
  localparam int NSH = 8;
  localparam logic [3:0] F_RESET = 4'd0;
  localparam logic [3:0] F_INTR  = 4'd3;
  localparam logic [3:0] F_PAL   = 4'd12;

  logic [AW-1:0] pc_q, npc_q, exc_q;
  logic          sh_q, rf_q, se_q;
  logic [13:0]   ofs;

  always_comb begin
    case (fault_i)
      F_RESET: ofs = 14'h0001;
      4'd1:    ofs = 14'h0401;
      4'd2:    ofs = 14'h0501;
      F_INTR:  ofs = 14'h0101;
      4'd4:    ofs = 14'h0201;
      4'd5:    ofs = 14'h0281;
      4'd6:    ofs = 14'h0301;
      4'd7:    ofs = 14'h0381;
      4'd8:    ofs = 14'h0181;
      4'd9:    ofs = 14'h0081;
      4'd11:   ofs = 14'h0581;
      F_PAL:   ofs = 14'h2001;
      4'd13:   ofs = 14'h0501;
      default: ofs = 14'h0481;
    endcase
  end

  wire           priv     = pc_i[0];
  wire [AW-1:0]  vec      = base_i + AW'(ofs);
  wire           keep_exc = (fault_i == F_INTR) && priv;
  wire [AW-1:0]  save     = (fault_i == F_PAL) ? pc_i + AW'(4) : pc_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= base_i + AW'(1);
      npc_q <= base_i + AW'(5);
      exc_q <= '0;
      sh_q  <= 1'b1;
      rf_q  <= 1'b0;
      se_q  <= 1'b0;
    end else begin
      rf_q <= 1'b0;
      se_q <= 1'b0;
      if (trap_i) begin
        pc_q  <= vec;
        npc_q <= vec + AW'(4);
        if (!keep_exc) exc_q <= save;
        if (!priv) begin
          if (sh_q) se_q <= 1'b1;
          sh_q <= 1'b1;
        end
      end else if (rei_i) begin
        if (!priv) begin
          rf_q <= 1'b1;
        end else begin
          pc_q  <= exc_q;
          npc_q <= exc_q + AW'(4);
          if (!exc_q[0]) begin
            if (!sh_q) se_q <= 1'b1;
            sh_q <= 1'b0;
          end
        end
      end
    end
  end

  assign pc_o        = pc_q;
  assign npc_o       = npc_q;
  assign exc_o       = exc_q;
  assign shadow_o    = sh_q;
  assign rei_fault_o = rf_q;
  assign swap_err_o  = se_q;

  function automatic logic is_sh(input logic [RA-1:0] a);
    return ((a >= RA'(8)) && (a <= RA'(14))) || (a == RA'(25));
  endfunction

  function automatic logic [2:0] slot(input logic [RA-1:0] a);
    return (a == RA'(25)) ? 3'd7 : 3'(a - RA'(8));
  endfunction

  logic [DW-1:0] main_q [NREG];
  logic [DW-1:0] shad_q [NSH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) main_q[i] <= '0;
      for (int j = 0; j < NSH; j++) shad_q[j] <= '0;
    end else if (rf_we) begin
      if (sh_q && is_sh(rf_waddr)) shad_q[slot(rf_waddr)] <= rf_wdata;
      else                         main_q[rf_waddr]       <= rf_wdata;
    end
  end

  assign rf_rdata = (sh_q && is_sh(rf_raddr)) ? shad_q[slot(rf_raddr)] : main_q[rf_raddr];
endmodule

// File: rtl/trap_dispatch_chk.sv
module trap_dispatch_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] pc_i,
  input logic [3:0]    fault_i,
  input logic          trap_i,
  input logic          rei_i,
  input logic [AW-1:0] pc_o,
  input logic [AW-1:0] npc_o,
  input logic [AW-1:0] exc_o,
  input logic          shadow_o,
  input logic          rei_fault_o,
  input logic          swap_err_o
);
  assert_npc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    npc_o == pc_o + AW'(4));

  assert_intr_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i && fault_i == 4'd3 && pc_i[0] |=> $stable(exc_o));

  assert_pal_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i && fault_i == 4'd12 |=> exc_o == $past(pc_i) + AW'(4));

  assert_shadow_in_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i && !pc_i[0] |=> shadow_o);

  assert_shadow_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i && pc_i[0] |=> $stable(shadow_o));

  assert_rei_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rei_i && !trap_i && !pc_i[0] |=> rei_fault_o && $stable(pc_o) && $stable(shadow_o));

  assert_rei_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rei_i && !trap_i && pc_i[0] |=> pc_o == $past(exc_o));

  assert_redundant_swap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i && !pc_i[0] && shadow_o |=> swap_err_o);

  assert_trap_priority_R11: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i && rei_i |=> !rei_fault_o);
endmodule

bind trap_dispatch trap_dispatch_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .fault_i(fault_i), .trap_i(trap_i),
  .rei_i(rei_i), .pc_o(pc_o), .npc_o(npc_o), .exc_o(exc_o), .shadow_o(shadow_o),
  .rei_fault_o(rei_fault_o), .swap_err_o(swap_err_o)
);

// File: tb/tb_trap_dispatch.sv
module tb_trap_dispatch;
  localparam int AW = 32, DW = 32, NREG = 32, RA = $clog2(NREG);
  localparam logic [AW-1:0] BASE = 32'h0001_0000;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] pc_i = '0, base_i = BASE;
  logic [3:0] fault_i = '0;
  logic trap_i = 0, rei_i = 0, rf_we = 0;
  logic [RA-1:0] rf_waddr = '0, rf_raddr = '0;
  logic [DW-1:0] rf_wdata = '0, rf_rdata;
  logic [AW-1:0] pc_o, npc_o, exc_o;
  logic shadow_o, rei_fault_o, swap_err_o;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  trap_dispatch #(.AW(AW), .DW(DW), .NREG(NREG)) dut (
    .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .fault_i(fault_i), .trap_i(trap_i),
    .rei_i(rei_i), .base_i(base_i), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .pc_o(pc_o),
    .npc_o(npc_o), .exc_o(exc_o), .shadow_o(shadow_o), .rei_fault_o(rei_fault_o),
    .swap_err_o(swap_err_o)
  );

  // {trap, rei, fault, pc_i, exp pc, exp resume, exp shadow, exp rei_fault, exp swap_err}
  localparam int NV = 22;
  localparam logic [104:0] VEC [NV] = '{
    {1'b0,1'b1,4'd0 ,32'h10041,32'h00000,32'h00000,1'b0,1'b0,1'b0}, // R8 even resume -> leave shadow
    {1'b1,1'b0,4'd6 ,32'h02000,32'h10301,32'h02000,1'b1,1'b0,1'b0}, // R2 R6
    {1'b0,1'b1,4'd0 ,32'h10305,32'h02000,32'h02000,1'b0,1'b0,1'b0}, // R8
    {1'b1,1'b0,4'd12,32'h03000,32'h12001,32'h03004,1'b1,1'b0,1'b0}, // R5
    {1'b1,1'b0,4'd3 ,32'h12005,32'h10101,32'h03004,1'b1,1'b0,1'b0}, // R4 interrupt in privileged mode
    {1'b1,1'b0,4'd5 ,32'h10105,32'h10281,32'h10105,1'b1,1'b0,1'b0}, // R6 privileged trap keeps shadow
    {1'b0,1'b1,4'd0 ,32'h10285,32'h10105,32'h10105,1'b1,1'b0,1'b0}, // R8 odd resume keeps shadow
    {1'b1,1'b1,4'd1 ,32'h10109,32'h10401,32'h10109,1'b1,1'b0,1'b0}, // R11 trap wins
    {1'b0,1'b1,4'd0 ,32'h10405,32'h10109,32'h10109,1'b1,1'b0,1'b0},
    {1'b1,1'b0,4'd13,32'h04000,32'h10501,32'h04000,1'b1,1'b0,1'b1}, // R10 shadow already on
    {1'b0,1'b1,4'd0 ,32'h10505,32'h04000,32'h04000,1'b0,1'b0,1'b0},
    {1'b0,1'b1,4'd0 ,32'h04000,32'h04000,32'h04000,1'b0,1'b1,1'b0}, // R7
    {1'b0,1'b1,4'd0 ,32'h10001,32'h04000,32'h04000,1'b0,1'b0,1'b1}, // R10 shadow already off
    {1'b1,1'b0,4'd8 ,32'h04004,32'h10181,32'h04004,1'b1,1'b0,1'b0},
    {1'b1,1'b0,4'd15,32'h10185,32'h10481,32'h10185,1'b1,1'b0,1'b0}, // R12
    {1'b1,1'b0,4'd11,32'h10481,32'h10581,32'h10481,1'b1,1'b0,1'b0},
    {1'b1,1'b0,4'd9 ,32'h10585,32'h10081,32'h10585,1'b1,1'b0,1'b0},
    {1'b1,1'b0,4'd7 ,32'h10085,32'h10381,32'h10085,1'b1,1'b0,1'b0},
    {1'b1,1'b0,4'd4 ,32'h10385,32'h10201,32'h10385,1'b1,1'b0,1'b0},
    {1'b1,1'b0,4'd2 ,32'h10205,32'h10501,32'h10205,1'b1,1'b0,1'b0},
    {1'b1,1'b0,4'd10,32'h10505,32'h10481,32'h10505,1'b1,1'b0,1'b0},
    {1'b1,1'b0,4'd14,32'h10485,32'h10481,32'h10485,1'b1,1'b0,1'b0}  // R12
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    rf_we = 1; rf_waddr = RA'(a); rf_wdata = d;
    @(negedge clk);
    rf_we = 0;
  endtask

  task automatic rd(input string tag, input int a, input logic [DW-1:0] exp);
    rf_raddr = RA'(a);
    #1;
    chk(tag, 64'(rf_rdata), 64'(exp));
  endtask

  task automatic req(input logic t, input logic r, input logic [3:0] f, input logic [AW-1:0] p);
    trap_i = t; rei_i = r; fault_i = f; pc_i = p;
    @(negedge clk);
    trap_i = 0; rei_i = 0;
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 pc", 64'(pc_o), 64'(BASE + 1));
    chk("R1 npc", 64'(npc_o), 64'(BASE + 5));
    chk("R1 shadow", 64'(shadow_o), 64'd1);
    chk("R1 resume", 64'(exc_o), 64'd0);
    chk("R1 pulses", 64'({rei_fault_o, swap_err_o}), 64'd0);

    for (int i = 0; i < NV; i++) begin
      logic [104:0] v;
      v = VEC[i];
      req(v[104], v[103], v[102:99], v[98:67]);
      chk($sformatf("R2/R8 pc vec%0d", i), 64'(pc_o), 64'(v[66:35]));
      chk($sformatf("R3 npc vec%0d", i), 64'(npc_o), 64'(v[66:35] + 32'd4));
      chk($sformatf("R4/R5 resume vec%0d", i), 64'(exc_o), 64'(v[34:3]));
      chk($sformatf("R6/R8 shadow vec%0d", i), 64'(shadow_o), 64'(v[2]));
      chk($sformatf("R7/R11 rei_fault vec%0d", i), 64'(rei_fault_o), 64'(v[1]));
      chk($sformatf("R10 swap_err vec%0d", i), 64'(swap_err_o), 64'(v[0]));
    end

    // R7: pulse lasts one cycle only
    req(1'b0, 1'b1, 4'd0, 32'h0000_4000);
    @(negedge clk);
    chk("R7 pulse cleared", 64'(rei_fault_o), 64'd0);

    // R9 shadow register bank
    do_reset();
    wr(9, 32'hAAAA_0009);
    wr(25, 32'hAAAA_0025);
    wr(15, 32'h0000_1515);
    wr(7, 32'h0000_0707);
    rd("R9 shadow r9", 9, 32'hAAAA_0009);
    req(1'b0, 1'b1, 4'd0, BASE + 1);
    chk("R8 shadow off", 64'(shadow_o), 64'd0);
    rd("R9 main r9", 9, 32'h0);
    rd("R9 main r25", 25, 32'h0);
    rd("R9 shared r15", 15, 32'h0000_1515);
    rd("R9 shared r7", 7, 32'h0000_0707);
    wr(9, 32'hBBBB_0009);
    rd("R9 main r9 write", 9, 32'hBBBB_0009);
    req(1'b1, 1'b0, 4'd3, 32'h0000_0100);
    chk("R4 user interrupt saves pc", 64'(exc_o), 64'h100);
    chk("R6 shadow on", 64'(shadow_o), 64'd1);
    rd("R9 shadow r9 back", 9, 32'hAAAA_0009);
    rd("R9 shadow r25 back", 25, 32'hAAAA_0025);
    rd("R9 shared r15 kept", 15, 32'h0000_1515);

    // R1 with a different base
    base_i = 32'h0020_0000;
    do_reset();
    chk("R1 pc new base", 64'(pc_o), 64'h0020_0001);
    rd("R1 regs cleared", 9, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule